// File: doc/BRIEF.md
# Key Edge Interrupt Controller

This block watches a vector of 64 debounced key status bits, one per key of an 8 by 8 matrix, and turns transitions on them into interrupts. Every key carries its own two-bit edge selector: off, rising only, falling only, or both. When a selected transition occurs, the key's pending bit is set and stays set until software writes a one to the matching clear bit. A per-key enable mask decides which pending bits reach the single level-sensitive interrupt output.

Software reaches the block through a simple word-addressed register port with a write strobe and a combinational read path. The key index used throughout is row*8 + column. Key scanning and debouncing happen upstream, so the status vector arrives here already clean.

Top module: `key_edge_irq`

## Requirements
- R1: After reset every edge selector, enable mask and pending bit reads as zero, and `irq` is low.
- R2: Key inputs that are already high when reset is released produce no pending bit. The previous-state sample is taken from the live inputs, so no startup transition is seen.
- R3: Selector value 1 sets a key's pending bit on a 0-to-1 transition of its status and ignores a 1-to-0 transition.
- R4: Selector value 2 sets a key's pending bit on a 1-to-0 transition and ignores a 0-to-1 transition.
- R5: Selector value 3 sets a key's pending bit on either transition.
- R6: Selector value 0 never sets the key's pending bit.
- R7: Word addresses 0 to 3 hold the selectors. Key k sits in word k/16 at bits [2*(k%16)+1 : 2*(k%16)]. Addresses 4 and 5 hold the masks, 6 and 7 are the clear words, and 8 and 9 hold the pending bits. In each of these pairs, key k is bit k%32 of word k/32.
- R8: A pending bit stays set after its key returns to its former level, until it is cleared.
- R9: Writing a clear word clears exactly the pending bits written as one. Zero bits in the written value leave their pending bits unchanged.
- R10: A selected transition in the same cycle as a clear of that bit leaves the bit set.
- R11: `irq` is high exactly when some key has both its pending bit and its mask bit set. With all masks zero, `irq` stays low whatever is pending.
- R12: A transition on one key changes no other key's pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| key_status | input | 64 | Debounced key levels, index row*8+column |
| reg_wr | input | 1 | Write strobe for the register port |
| reg_addr | input | 4 | Word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Level interrupt: any pending bit with its mask set |

## Verification
The same key is driven up and then down under each selector value. This separates the rising-only, falling-only, both-edge and off behaviours. Keys spread over all four selector words and both pending words (keys 5, 10, 20, 33, 40 and 63) confirm the field and bit positions. A single-key toggle with every selector set to both-edge shows that no other bit moves. Clear writes are tried with zero data, with partial data, and in the same cycle as a new transition, which separates the write-one-to-clear behaviour from the rule that a new transition wins. The mask is swept from all ones to none to a single matching bit and then a single non-matching bit, so the interrupt gating is seen on its own.

// File: rtl/key_edge_irq_pkg.sv
package key_edge_irq_pkg;

  // Per-key transition selector encoding
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_BOTH = 2'd3
  } edge_sel_e;

  localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/key_edge_cfg.sv
module key_edge_cfg #(
  parameter int unsigned NUM_KEYS    = 64,
  parameter int unsigned REG_W       = 32,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned N_SEL_REGS  = 4,
  parameter int unsigned N_BIT_REGS  = 2,
  parameter int unsigned MASK_BASE   = 4
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           reg_wr,
  input  logic [ADDR_W-1:0]              reg_addr,
  input  logic [REG_W-1:0]               reg_wdata,
  output logic [N_SEL_REGS*REG_W-1:0]    sel_flat,
  output logic [NUM_KEYS-1:0]            mask
);

  logic [N_SEL_REGS*REG_W-1:0] sel_q, sel_d;
  logic [N_BIT_REGS*REG_W-1:0] mask_q, mask_d;

  always_comb begin
    sel_d = sel_q;
    for (int i = 0; i < int'(N_SEL_REGS); i++) begin
      if (reg_wr && reg_addr == ADDR_W'(i))
        sel_d[REG_W*i +: REG_W] = reg_wdata;
    end
  end

  always_comb begin
    mask_d = mask_q;
    for (int j = 0; j < int'(N_BIT_REGS); j++) begin
      if (reg_wr && reg_addr == ADDR_W'(MASK_BASE + j))
        mask_d[REG_W*j +: REG_W] = reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      mask_q <= '0;
    end else begin
      sel_q  <= sel_d;
      mask_q <= mask_d;
    end
  end

  assign sel_flat = sel_q;
  assign mask     = mask_q[NUM_KEYS-1:0];

endmodule

// File: rtl/key_edge_detect.sv
module key_edge_detect
  import key_edge_irq_pkg::*;
#(
  parameter int unsigned NUM_KEYS = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NUM_KEYS-1:0]       key_status,
  input  logic [NUM_KEYS*SEL_W-1:0] sel_flat,
  output logic [NUM_KEYS-1:0]       hit,
  output logic                      armed
);

  logic [NUM_KEYS-1:0] prev_q;
  logic                armed_q;

  // Previous sample follows the live inputs every cycle, also during reset
  always_ff @(posedge clk) begin
    prev_q <= key_status;
  end

  // Comparison is allowed once a sample has been taken after reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  for (genvar k = 0; k < int'(NUM_KEYS); k++) begin : g_key
    edge_sel_e sel;
    logic      rise, fall;
    assign sel  = edge_sel_e'(sel_flat[SEL_W*k +: SEL_W]);
    assign rise = armed_q &  key_status[k] & ~prev_q[k];
    assign fall = armed_q & ~key_status[k] &  prev_q[k];
    always_comb begin
      unique case (sel)
        EDGE_RISE: hit[k] = rise;
        EDGE_FALL: hit[k] = fall;
        EDGE_BOTH: hit[k] = rise | fall;
        default:   hit[k] = 1'b0;
      endcase
    end
  end

  assign armed = armed_q;

endmodule

// File: rtl/key_edge_pending.sv
module key_edge_pending #(
  parameter int unsigned NUM_KEYS = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] hit,
  input  logic [NUM_KEYS-1:0] clr,
  output logic [NUM_KEYS-1:0] pending
);

  logic [NUM_KEYS-1:0] pend_q, pend_d;

  // A new transition takes priority over a clear of the same bit
  always_comb begin
    pend_d = (pend_q & ~clr) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;

endmodule

// File: rtl/key_edge_irq.sv
module key_edge_irq
  import key_edge_irq_pkg::*;
#(
  parameter int unsigned NUM_KEYS = 64,
  parameter int unsigned REG_W    = 32,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_KEYS-1:0] key_status,
  input  logic                reg_wr,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [REG_W-1:0]    reg_wdata,
  output logic [REG_W-1:0]    reg_rdata,
  output logic                irq
);

  localparam int unsigned KEYS_PER_SEL = REG_W / SEL_W;
  localparam int unsigned N_SEL_REGS   = NUM_KEYS / KEYS_PER_SEL;
  localparam int unsigned N_BIT_REGS   = NUM_KEYS / REG_W;
  localparam int unsigned MASK_BASE    = N_SEL_REGS;
  localparam int unsigned CLR_BASE     = MASK_BASE + N_BIT_REGS;
  localparam int unsigned STAT_BASE    = CLR_BASE + N_BIT_REGS;

  logic [NUM_KEYS*SEL_W-1:0] sel_flat;
  logic [NUM_KEYS-1:0]       mask;
  logic [NUM_KEYS-1:0]       hit;
  logic [NUM_KEYS-1:0]       clr;
  logic [NUM_KEYS-1:0]       pending;
  logic                      armed;

  key_edge_cfg #(
    .NUM_KEYS   (NUM_KEYS),
    .REG_W      (REG_W),
    .ADDR_W     (ADDR_W),
    .N_SEL_REGS (N_SEL_REGS),
    .N_BIT_REGS (N_BIT_REGS),
    .MASK_BASE  (MASK_BASE)
  ) u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .sel_flat  (sel_flat),
    .mask      (mask)
  );

  key_edge_detect #(
    .NUM_KEYS (NUM_KEYS)
  ) u_detect (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_status (key_status),
    .sel_flat   (sel_flat),
    .hit        (hit),
    .armed      (armed)
  );

  // Clear words: write-one-to-clear, decoded per word
  for (genvar j = 0; j < int'(N_BIT_REGS); j++) begin : g_clr
    assign clr[REG_W*j +: REG_W] =
      (reg_wr && reg_addr == ADDR_W'(CLR_BASE + j)) ? reg_wdata : '0;
  end

  key_edge_pending #(
    .NUM_KEYS (NUM_KEYS)
  ) u_pending (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (hit),
    .clr     (clr),
    .pending (pending)
  );

  // Read path; clear words and unused addresses return zero
  always_comb begin
    reg_rdata = '0;
    for (int i = 0; i < int'(N_SEL_REGS); i++) begin
      if (reg_addr == ADDR_W'(i))
        reg_rdata = sel_flat[REG_W*i +: REG_W];
    end
    for (int j = 0; j < int'(N_BIT_REGS); j++) begin
      if (reg_addr == ADDR_W'(MASK_BASE + j))
        reg_rdata = mask[REG_W*j +: REG_W];
      if (reg_addr == ADDR_W'(STAT_BASE + j))
        reg_rdata = pending[REG_W*j +: REG_W];
    end
  end

  assign irq = |(pending & mask);

endmodule

// File: rtl/key_edge_irq_chk.sv
module key_edge_irq_chk
  import key_edge_irq_pkg::*;
#(
  parameter int unsigned NUM_KEYS = 64
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic [NUM_KEYS-1:0]       key_status,
  input logic [NUM_KEYS*SEL_W-1:0] sel_flat,
  input logic [NUM_KEYS-1:0]       mask,
  input logic [NUM_KEYS-1:0]       hit,
  input logic [NUM_KEYS-1:0]       clr,
  input logic [NUM_KEYS-1:0]       pending,
  input logic                      armed,
  input logic                      irq
);

  // R2: nothing becomes pending before the first post-reset sample
  assert_no_startup_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && pending == '0) |=> (pending == '0));

  // R11: an all-zero mask keeps the interrupt low
  assert_mask_gates_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  for (genvar k = 0; k < int'(NUM_KEYS); k++) begin : g_key
    logic [SEL_W-1:0] s;
    assign s = sel_flat[SEL_W*k +: SEL_W];

    // R3: rising-only cannot set the bit while the key is low
    assert_rise_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (s == EDGE_RISE && !pending[k] && !key_status[k]) |=> !pending[k]);

    // R4: falling-only cannot set the bit while the key is high
    assert_fall_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (s == EDGE_FALL && !pending[k] && key_status[k]) |=> !pending[k]);

    // R6: a disabled key never becomes pending
    assert_sel_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (s == EDGE_OFF && !pending[k]) |=> !pending[k]);

    // R8: without a clear, a pending bit holds
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (pending[k] && !clr[k]) |=> pending[k]);

    // R9: a clear with no coincident transition empties the bit
    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[k] && !hit[k]) |=> !pending[k]);

    // R10: a coincident transition wins over a clear
    assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[k] && hit[k]) |=> pending[k]);
  end

endmodule

bind key_edge_irq key_edge_irq_chk #(
  .NUM_KEYS (NUM_KEYS)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .key_status (key_status),
  .sel_flat   (sel_flat),
  .mask       (mask),
  .hit        (hit),
  .clr        (clr),
  .pending    (pending),
  .armed      (armed),
  .irq        (irq)
);

// File: tb/key_edge_irq_tb.sv
module key_edge_irq_tb;

  localparam int CLK_PERIOD = 10;

  localparam logic [3:0] A_SEL0  = 4'd0;
  localparam logic [3:0] A_SEL1  = 4'd1;
  localparam logic [3:0] A_SEL2  = 4'd2;
  localparam logic [3:0] A_SEL3  = 4'd3;
  localparam logic [3:0] A_MASK0 = 4'd4;
  localparam logic [3:0] A_MASK1 = 4'd5;
  localparam logic [3:0] A_CLR0  = 4'd6;
  localparam logic [3:0] A_CLR1  = 4'd7;
  localparam logic [3:0] A_STAT0 = 4'd8;
  localparam logic [3:0] A_STAT1 = 4'd9;

  logic        clk;
  logic        rst_n;
  logic [63:0] key_status;
  logic        reg_wr;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks;
  int errors;
  logic [63:0] keys;

  key_edge_irq u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .key_status (key_status),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .irq        (irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic flip(input int k);
    @(negedge clk);
    keys[k] = ~keys[k];
    key_status = keys;
  endtask

  task automatic status64(output logic [63:0] s);
    logic [31:0] lo, hi;
    rd(A_STAT0, lo);
    rd(A_STAT1, hi);
    s = {hi, lo};
  endtask

  task automatic prep();
    wr(A_SEL0, '0); wr(A_SEL1, '0); wr(A_SEL2, '0); wr(A_SEL3, '0);
    wr(A_MASK0, '1); wr(A_MASK1, '1);
    wr(A_CLR0, '1); wr(A_CLR1, '1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    logic [63:0] s;
    for (int a = 0; a < 10; a++) begin
      if (a != 6 && a != 7) begin
        rd(4'(a), d);
        check("R1 reset register", {32'd0, d}, 64'd0);
      end
    end
    check("R1 reset irq", {63'd0, irq}, 64'd0);
    wr(A_SEL0, '1); wr(A_SEL1, '1); wr(A_SEL2, '1); wr(A_SEL3, '1);
    repeat (3) @(negedge clk);
    status64(s);
    check("R2 no startup edge", s, 64'd0);
  endtask

  task automatic t_rise();
    logic [63:0] s;
    logic [31:0] d;
    prep();
    wr(A_SEL0, 32'h1 << 20);   // key 10 rising
    wr(A_SEL2, 32'h1 << 16);   // key 40 rising
    rd(A_SEL2, d);
    check("R7 selector readback", {32'd0, d}, 64'h0000_0000_0001_0000);
    flip(10);
    status64(s);
    check("R3 rising sets key 10", s, 64'h1 << 10);
    check("R11 irq with mask", {63'd0, irq}, 64'd1);
    wr(A_CLR0, 32'h1 << 10);
    flip(10);
    status64(s);
    check("R3 falling ignored", s, 64'd0);
    flip(40);
    rd(A_STAT1, d);
    check("R7 key 40 in word 9 bit 8", {32'd0, d}, 64'h100);
    flip(40);
  endtask

  task automatic t_fall();
    logic [63:0] s;
    prep();
    wr(A_SEL3, 32'h2 << 30);   // key 63 falling
    flip(63);
    status64(s);
    check("R4 rising ignored", s, 64'd0);
    flip(63);
    status64(s);
    check("R4 falling sets key 63", s, 64'h1 << 63);
  endtask

  task automatic t_both();
    logic [63:0] s;
    prep();
    wr(A_SEL0, 32'h3 << 10);   // key 5 both
    flip(5);                   // key 5 starts high -> falls
    status64(s);
    check("R5 falling sets key 5", s, 64'h1 << 5);
    wr(A_CLR0, 32'h1 << 5);
    flip(5);
    status64(s);
    check("R5 rising sets key 5", s, 64'h1 << 5);
  endtask

  task automatic t_off();
    logic [63:0] s;
    prep();
    flip(0);
    flip(0);
    repeat (2) @(negedge clk);
    status64(s);
    check("R6 disabled key", s, 64'd0);
  endtask

  task automatic t_sticky_clear();
    logic [63:0] s;
    prep();
    wr(A_SEL0, 32'h3 << 10);   // key 5 both
    wr(A_SEL1, 32'h1 << 8);    // key 20 rising
    flip(20);
    flip(20);
    flip(5);
    repeat (3) @(negedge clk);
    status64(s);
    check("R8 sticky after release", s, (64'h1 << 20) | (64'h1 << 5));
    wr(A_CLR0, 32'h0);
    status64(s);
    check("R9 zero clear no effect", s, (64'h1 << 20) | (64'h1 << 5));
    wr(A_CLR0, 32'h1 << 20);
    status64(s);
    check("R9 partial clear", s, 64'h1 << 5);
    // R10: toggle key 5 in the same cycle as its clear
    @(negedge clk);
    keys[5] = ~keys[5]; key_status = keys;
    reg_wr = 1'b1; reg_addr = A_CLR0; reg_wdata = 32'h1 << 5;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
    status64(s);
    check("R10 edge beats clear", s, 64'h1 << 5);
  endtask

  task automatic t_mask();
    prep();
    wr(A_SEL0, 32'h3 << 10);
    flip(5);
    @(negedge clk);
    check("R11 irq all masks", {63'd0, irq}, 64'd1);
    wr(A_MASK0, '0); wr(A_MASK1, '0);
    #1 check("R11 irq no masks", {63'd0, irq}, 64'd0);
    wr(A_MASK0, 32'h1 << 5);
    #1 check("R11 irq matching mask", {63'd0, irq}, 64'd1);
    wr(A_MASK0, 32'h1 << 6);
    #1 check("R11 irq other mask", {63'd0, irq}, 64'd0);
  endtask

  task automatic t_indep();
    logic [63:0] s;
    prep();
    wr(A_SEL0, '1); wr(A_SEL1, '1); wr(A_SEL2, '1); wr(A_SEL3, '1);
    flip(33);
    status64(s);
    check("R12 only key 33", s, 64'h1 << 33);
    wr(A_CLR1, 32'h1 << 1);
    status64(s);
    check("R9 clear word 7", s, 64'd0);
  endtask

  initial begin
    checks = 0; errors = 0;
    keys = 64'hA5; key_status = keys;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    rst_n = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_off();
    t_sticky_clear();
    t_mask();
    t_indep();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule